// File: doc/BRIEF.md
# Microwire Serial Memory Slave Interface

This block is the serial front end that sits between a three-wire Microwire host and a small nonvolatile storage array. It samples chip-select, serial clock and serial data in on the system clock through a configurable synchronizer, and acts on rising serial-clock edges. It waits for a start bit, collects a two-bit opcode, an address and (when needed) a data word, and decodes seven commands: read, write, erase, erase-all, write-all, write-enable and write-disable.

Reads are served from a memory-side read port. The address is presented on `mem_rd_addr` and the word is taken from `mem_rd_data`. The word goes out on the serial data-out pin behind one leading zero. While the host keeps the device selected and keeps clocking, the read continues through the following addresses and wraps to zero. Program commands are held until chip-select falls. At that point they become one-cycle request pulses, carrying an address and a data word, to a program engine outside this block. The engine reports back on `mem_busy`. While a program cycle is pending, the data-out pin gives a ready/busy flag until the host releases it.

The `org_wide` input selects 16-bit words when high and 8-bit words when low. In the 8-bit organization the address is one bit longer. A board that leaves this pin floating is expected to pull it high.

Top module: `mw_slave`

## Requirements
- R1: Zero bits clocked in while the device is selected and no command is in progress are ignored. A command begins at the first 1 sampled on a rising serial-clock edge.
- R2: After the start bit come two opcode bits, sent first bit first: 10 is read, 11 is erase, 01 is write and 00 is the special group. Within the special group, the two most significant address bits select the command: 11 enables programming, 00 disables it, 10 erases everything and 01 writes one word everywhere. The remaining address bits are ignored.
- R3: With `org_wide` high, the address has ADDR_W bits and write data has 16 bits. With `org_wide` low, the address has ADDR_W+1 bits and write data has 8 bits, presented zero-extended on `prog_data`. Both fields are sent MSB first.
- R4: On the rising edge that carries the last read address bit, `mw_doe` goes high and `mw_do` shows a single 0. From the next rising edge on, the addressed word is shifted out MSB first, one bit per rising edge. In 8-bit mode only `mem_rd_data[7:0]` is sent.
- R5: While the device stays selected and the clock keeps running, the read moves straight on to the next address with no extra zero. After the last address (2^ADDR_W-1 wide, 2^(ADDR_W+1)-1 narrow) it continues at address 0.
- R6: `mw_doe` is low whenever chip-select is low, and it is high only during a read or while a program status is pending.
- R7: Programming is disabled after reset. Write, erase, erase-all and write-all produce no request and no status while it is disabled. The enable and disable commands set and clear it, and `write_enabled` shows the current state.
- R8: A complete program command produces exactly one single-cycle pulse on its request output (`prog_write`, `prog_erase`, `prog_erase_all` or `prog_write_all`) after chip-select falls. `prog_addr` and `prog_data` hold the received fields.
- R9: After a request has been issued, whenever chip-select is high, `mw_doe` is high and `mw_do` shows 0 while `mem_busy` is high and 1 when it is low.
- R10: A 1 clocked in while the status shows ready releases the status, and `mw_doe` falls after that edge. A 1 clocked in while busy has no effect, and no command is decoded until the status has been released.
- R11: If chip-select falls before a command is complete, the partial command is discarded and no request is issued.
- R12: After reset, `mw_doe` is low, `write_enabled` is low and no request pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mw_cs | input | 1 | Chip-select from the host, active high |
| mw_sk | input | 1 | Serial clock from the host |
| mw_di | input | 1 | Serial data from the host |
| org_wide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| mw_do | output | 1 | Serial data / ready-busy flag toward the host |
| mw_doe | output | 1 | Output enable for the data-out pad driver |
| mem_rd_addr | output | ADDR_W+1 | Word address presented to the read port |
| mem_rd_data | input | WORD_W | Word returned for mem_rd_addr |
| mem_busy | input | 1 | Program engine busy |
| prog_addr | output | ADDR_W+1 | Address of the last program request |
| prog_data | output | WORD_W | Data of the last program request |
| prog_write | output | 1 | Single-word write request pulse |
| prog_erase | output | 1 | Single-word erase request pulse |
| prog_erase_all | output | 1 | Whole-array erase request pulse |
| prog_write_all | output | 1 | Whole-array write request pulse |
| write_enabled | output | 1 | Current programming enable state |

## Verification
Two events can meet on the same serial-clock edge: the release bit of the status flag and the end of the busy period reported by the program engine. Whether that edge releases the pin depends only on the state of `mem_busy` at that edge. The bench clocks in a 1 while its memory model still holds busy and checks that the flag stays driven at 0. It then waits for the model to go ready, checks for a driven 1, and clocks in another 1, which must take the pin to high impedance. In the same spirit, the word boundary where the address increments meets the wrap to zero. The bench starts sequential reads at the top address in both organizations and checks that the next word is the word at address 0, with no zero bit in between.

// File: rtl/mw_pkg.sv
package mw_pkg;

   localparam logic [1:0] OPC_SPECIAL = 2'b00;
   localparam logic [1:0] OPC_WRITE   = 2'b01;
   localparam logic [1:0] OPC_READ    = 2'b10;
   localparam logic [1:0] OPC_ERASE   = 2'b11;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_OPC,
      RX_ADDR,
      RX_DATA,
      RX_DONE,
      RX_READ
   } rx_state_t;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_READ,
      CMD_WRITE,
      CMD_ERASE,
      CMD_WEN,
      CMD_WDIS,
      CMD_ERASE_ALL,
      CMD_WRITE_ALL
   } cmd_t;

   // Opcode plus the two leading address bits give the command.
   function automatic cmd_t decode_cmd(input logic [1:0] opc, input logic [1:0] sel);
      cmd_t c;
      case (opc)
         OPC_READ:  c = CMD_READ;
         OPC_WRITE: c = CMD_WRITE;
         OPC_ERASE: c = CMD_ERASE;
         default: begin
            case (sel)
               2'b11:   c = CMD_WEN;
               2'b00:   c = CMD_WDIS;
               2'b10:   c = CMD_ERASE_ALL;
               default: c = CMD_WRITE_ALL;
            endcase
         end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      stage_q[i] <= '0;
               else if (i == 0) stage_q[i] <= d;
               else             stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mw_rx.sv
module mw_rx
   import mw_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              sk_rise,
   input  logic              di,
   input  logic              wide,
   input  logic              hold,
   output logic              frame_done,
   output cmd_t              cmd,
   output logic [ADDR_W:0]   addr,
   output logic [WORD_W-1:0] data,
   output logic              rd_start
);

   localparam int AW8   = ADDR_W + 1;
   localparam int HALF  = WORD_W / 2;
   localparam int CNT_W = $clog2(WORD_W + AW8) + 1;

   rx_state_t          st_q;
   logic [1:0]         opc_q;
   logic [AW8-1:0]     addr_q;
   logic [WORD_W-1:0]  data_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   alen, dlen;
   logic [AW8-1:0]     addr_nx;

   function automatic logic [1:0] lead_two(input logic [AW8-1:0] a, input logic w);
      return w ? a[ADDR_W-1 -: 2] : a[ADDR_W -: 2];
   endfunction

   assign alen    = wide ? CNT_W'(ADDR_W) : CNT_W'(AW8);
   assign dlen    = wide ? CNT_W'(WORD_W) : CNT_W'(HALF);
   assign addr_nx = {addr_q[AW8-2:0], di};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= RX_IDLE;
         opc_q    <= '0;
         addr_q   <= '0;
         data_q   <= '0;
         cnt_q    <= '0;
         rd_start <= 1'b0;
      end else if (!cs) begin
         st_q     <= RX_IDLE;
         rd_start <= 1'b0;
      end else begin
         rd_start <= 1'b0;
         if (sk_rise && !hold) begin
            case (st_q)
               RX_IDLE: if (di) begin
                  st_q   <= RX_OPC;
                  cnt_q  <= '0;
                  addr_q <= '0;
                  data_q <= '0;
               end
               RX_OPC: begin
                  opc_q <= {opc_q[0], di};
                  if (cnt_q == CNT_W'(1)) begin
                     st_q  <= RX_ADDR;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_ADDR: begin
                  addr_q <= addr_nx;
                  if (cnt_q == alen - CNT_W'(1)) begin
                     cnt_q <= '0;
                     case (decode_cmd(opc_q, lead_two(addr_nx, wide)))
                        CMD_READ: begin
                           st_q     <= RX_READ;
                           rd_start <= 1'b1;
                        end
                        CMD_WRITE, CMD_WRITE_ALL: st_q <= RX_DATA;
                        default:                  st_q <= RX_DONE;
                     endcase
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  data_q <= {data_q[WORD_W-2:0], di};
                  if (cnt_q == dlen - CNT_W'(1)) st_q <= RX_DONE;
                  else                           cnt_q <= cnt_q + 1'b1;
               end
               default: st_q <= st_q;
            endcase
         end
      end
   end

   assign frame_done = (st_q == RX_DONE);
   assign cmd        = decode_cmd(opc_q, lead_two(addr_q, wide));
   assign addr       = addr_q;
   assign data       = data_q;

   // R2: a read is only launched from the read opcode
   a_r2_read_opcode: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |-> (opc_q == OPC_READ));

   // R11: a deselect always leaves no finished frame behind
   a_r11_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> !frame_done);

endmodule

// File: rtl/mw_tx.sv
module mw_tx #(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              sk_rise,
   input  logic              wide,
   input  logic              rd_start,
   input  logic [ADDR_W:0]   start_addr,
   input  logic [WORD_W-1:0] mem_rd_data,
   output logic [ADDR_W:0]   mem_rd_addr,
   output logic              rd_active,
   output logic              rd_bit
);

   localparam int AW8   = ADDR_W + 1;
   localparam int HALF  = WORD_W / 2;
   localparam int CNT_W = $clog2(WORD_W) + 1;

   logic               active_q, bit_q;
   logic [WORD_W-1:0]  sh_q, word;
   logic [CNT_W-1:0]   rem_q, dlen;
   logic [AW8-1:0]     addr_q, last_addr, next_addr;
   logic               load;

   assign dlen      = wide ? CNT_W'(WORD_W) : CNT_W'(HALF);
   assign last_addr = wide ? {1'b0, {ADDR_W{1'b1}}} : {AW8{1'b1}};
   assign next_addr = (addr_q == last_addr) ? '0 : addr_q + 1'b1;
   assign word      = wide ? mem_rd_data : {mem_rd_data[HALF-1:0], {(WORD_W-HALF){1'b0}}};
   assign load      = active_q && sk_rise && (rem_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         bit_q    <= 1'b0;
         sh_q     <= '0;
         rem_q    <= '0;
         addr_q   <= '0;
      end else if (!cs) begin
         active_q <= 1'b0;
         bit_q    <= 1'b0;
      end else if (rd_start) begin
         active_q <= 1'b1;
         bit_q    <= 1'b0;
         rem_q    <= '0;
         addr_q   <= start_addr;
      end else if (load) begin
         bit_q    <= word[WORD_W-1];
         sh_q     <= {word[WORD_W-2:0], 1'b0};
         rem_q    <= dlen - CNT_W'(1);
         addr_q   <= next_addr;
      end else if (active_q && sk_rise) begin
         bit_q    <= sh_q[WORD_W-1];
         sh_q     <= {sh_q[WORD_W-2:0], 1'b0};
         rem_q    <= rem_q - CNT_W'(1);
      end
   end

   assign mem_rd_addr = addr_q;
   assign rd_active   = active_q;
   assign rd_bit      = bit_q;

   // R4: the first bit of a read is the leading zero
   a_r4_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q) |-> !bit_q);

   // R5: each word load steps the address by one or wraps to zero
   a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !rd_start && load) |=> ((addr_q == $past(addr_q) + 1'b1) || (addr_q == '0)));

endmodule

// File: rtl/mw_slave.sv
module mw_slave
   import mw_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mw_cs,
   input  logic              mw_sk,
   input  logic              mw_di,
   input  logic              org_wide,
   output logic              mw_do,
   output logic              mw_doe,
   output logic [ADDR_W:0]   mem_rd_addr,
   input  logic [WORD_W-1:0] mem_rd_data,
   input  logic              mem_busy,
   output logic [ADDR_W:0]   prog_addr,
   output logic [WORD_W-1:0] prog_data,
   output logic              prog_write,
   output logic              prog_erase,
   output logic              prog_erase_all,
   output logic              prog_write_all,
   output logic              write_enabled
);

   localparam int HALF = WORD_W / 2;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("mw_slave: ADDR_W must be at least 2");
      end
      if (WORD_W < 4 || (WORD_W % 2) != 0) begin : g_bad_word
         $error("mw_slave: WORD_W must be even and at least 4");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("mw_slave: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [2:0] pins_s;
   logic       cs_s, sk_s, di_s, cs_d, sk_d;
   logic       sk_rise, cs_fall;

   mw_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d ({mw_cs, mw_sk, mw_di}),
      .q (pins_s)
   );

   assign {cs_s, sk_s, di_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d <= 1'b0;
         sk_d <= 1'b0;
      end else begin
         cs_d <= cs_s;
         sk_d <= sk_s;
      end
   end

   assign sk_rise = sk_s & ~sk_d;
   assign cs_fall = ~cs_s & cs_d;

   logic              status_q, wen_q;
   logic              frame_done, rd_start, rd_active, rd_bit;
   cmd_t              cmd;
   logic [ADDR_W:0]   rx_addr;
   logic [WORD_W-1:0] rx_data;

   mw_rx #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rx (
      .clk (clk),
      .rst_n (rst_n),
      .cs (cs_s),
      .sk_rise (sk_rise),
      .di (di_s),
      .wide (org_wide),
      .hold (status_q),
      .frame_done (frame_done),
      .cmd (cmd),
      .addr (rx_addr),
      .data (rx_data),
      .rd_start (rd_start)
   );

   mw_tx #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_tx (
      .clk (clk),
      .rst_n (rst_n),
      .cs (cs_s),
      .sk_rise (sk_rise),
      .wide (org_wide),
      .rd_start (rd_start),
      .start_addr (rx_addr),
      .mem_rd_data (mem_rd_data),
      .mem_rd_addr (mem_rd_addr),
      .rd_active (rd_active),
      .rd_bit (rd_bit)
   );

   logic execute;
   assign execute = cs_fall && frame_done && !status_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q          <= 1'b0;
         status_q       <= 1'b0;
         prog_addr      <= '0;
         prog_data      <= '0;
         prog_write     <= 1'b0;
         prog_erase     <= 1'b0;
         prog_erase_all <= 1'b0;
         prog_write_all <= 1'b0;
      end else begin
         prog_write     <= 1'b0;
         prog_erase     <= 1'b0;
         prog_erase_all <= 1'b0;
         prog_write_all <= 1'b0;
         if (execute) begin
            prog_addr <= rx_addr;
            prog_data <= org_wide ? rx_data : {{(WORD_W-HALF){1'b0}}, rx_data[HALF-1:0]};
            case (cmd)
               CMD_WEN:  wen_q <= 1'b1;
               CMD_WDIS: wen_q <= 1'b0;
               CMD_WRITE: if (wen_q) begin
                  prog_write <= 1'b1;
                  status_q   <= 1'b1;
               end
               CMD_ERASE: if (wen_q) begin
                  prog_erase <= 1'b1;
                  status_q   <= 1'b1;
               end
               CMD_ERASE_ALL: if (wen_q) begin
                  prog_erase_all <= 1'b1;
                  status_q       <= 1'b1;
               end
               CMD_WRITE_ALL: if (wen_q) begin
                  prog_write_all <= 1'b1;
                  status_q       <= 1'b1;
               end
               default: ;
            endcase
         end else if (sk_rise && cs_s && status_q && di_s && !mem_busy) begin
            status_q <= 1'b0;
         end
      end
   end

   assign write_enabled = wen_q;
   assign mw_doe        = cs_s & (rd_active | status_q);
   assign mw_do         = mw_doe & (rd_active ? rd_bit : ~mem_busy);

   // R6: the pin is never driven while deselected
   a_r6_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      mw_doe |-> cs_s);

   // R8: at most one request per cycle, and only right after a deselect
   a_r8_one_request: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_write, prog_erase, prog_erase_all, prog_write_all}));

   a_r8_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_write | prog_erase | prog_erase_all | prog_write_all) |-> !cs_d);

   // R10: the status flag is never released while the engine is busy
   a_r10_release_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_q) |-> !$past(mem_busy));

endmodule

// File: tb/mw_slave_test.sv
module mw_slave_test;

   localparam int AW   = 4;
   localparam int WW   = 16;
   localparam int HP   = 8;
   localparam int BUSY = 300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mw_cs = 1'b0, mw_sk = 1'b0, mw_di = 1'b0, org_wide = 1'b1;
   logic mw_do, mw_doe, mem_busy;
   logic [AW:0] mem_rd_addr, prog_addr;
   logic [WW-1:0] mem_rd_data, prog_data;
   logic prog_write, prog_erase, prog_erase_all, prog_write_all, write_enabled;

   always #2 clk = ~clk;

   mw_slave #(.ADDR_W(AW), .WORD_W(WW), .SYNC_STAGES(2)) uut (
      .clk (clk), .rst_n (rst_n),
      .mw_cs (mw_cs), .mw_sk (mw_sk), .mw_di (mw_di), .org_wide (org_wide),
      .mw_do (mw_do), .mw_doe (mw_doe),
      .mem_rd_addr (mem_rd_addr), .mem_rd_data (mem_rd_data), .mem_busy (mem_busy),
      .prog_addr (prog_addr), .prog_data (prog_data),
      .prog_write (prog_write), .prog_erase (prog_erase),
      .prog_erase_all (prog_erase_all), .prog_write_all (prog_write_all),
      .write_enabled (write_enabled)
   );

   function automatic logic [15:0] mval(input int a);
      return 16'(a * 32'h1357) ^ 16'hA5C3;
   endfunction

   assign mem_rd_data = mval(int'(mem_rd_addr));

   int busy_cnt = 0;
   int n_wr = 0, n_er = 0, n_eral = 0, n_wral = 0;
   int tests = 0, fails = 0;
   assign mem_busy = (busy_cnt != 0);

   always @(posedge clk) begin
      if (prog_write | prog_erase | prog_erase_all | prog_write_all) busy_cnt <= BUSY;
      else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (prog_write)     n_wr   <= n_wr + 1;
      if (prog_erase)     n_er   <= n_er + 1;
      if (prog_erase_all) n_eral <= n_eral + 1;
      if (prog_write_all) n_wral <= n_wral + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clock_bit(input logic b);
      @(negedge clk) mw_di = b;
      repeat (HP) @(negedge clk);
      mw_sk = 1'b1;
      repeat (HP) @(negedge clk);
      mw_sk = 1'b0;
   endtask

   task automatic send(input int val, input int n);
      for (int i = n - 1; i >= 0; i--) clock_bit(val[i]);
   endtask

   task automatic cs_on();
      @(negedge clk) mw_cs = 1'b1;
      repeat (HP) @(negedge clk);
   endtask

   task automatic cs_off();
      @(negedge clk) begin mw_cs = 1'b0; mw_di = 1'b0; end
      repeat (12) @(negedge clk);
   endtask

   // read nw words from a, checking leading zero, data and wrap
   task automatic t_read(input int a, input int nw, input logic wide, input int lead);
      int width, mask, cur;
      width = wide ? 16 : 8;
      mask  = wide ? (1 << AW) - 1 : (1 << (AW + 1)) - 1;
      org_wide = wide;
      cs_on();
      send(0, lead);                          // R1 leading zeros
      send(3'b110, 3);
      send(a, wide ? AW : AW + 1);            // R3 address length
      chk("R4 oe after address", mw_doe, 1);
      chk("R4 leading zero", mw_do, 0);
      cur = a;
      for (int w = 0; w < nw; w++) begin
         int got = 0;
         for (int b = 0; b < width; b++) begin
            clock_bit(1'b0);
            got = (got << 1) | int'(mw_do);
         end
         chk(w == 0 ? "R4 first word" : "R5 next word", got,
             wide ? int'(mval(cur)) : int'(mval(cur) & 16'hFF));
         cur = (cur + 1) & mask;
      end
      cs_off();
      chk("R6 oe low when deselected", mw_doe, 0);
   endtask

   // show status, try release while busy, then release when ready
   task automatic t_status();
      cs_on();
      chk("R9 status oe", mw_doe, 1);
      chk("R9 busy shows 0", mw_do, 0);
      clock_bit(1'b1);
      chk("R10 no release while busy", mw_doe, 1);
      repeat (BUSY + 20) @(negedge clk);
      chk("R9 ready shows 1", mw_do, 1);
      clock_bit(1'b1);
      chk("R10 released after 1", mw_doe, 0);
      cs_off();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R12 reset state
      chk("R12 oe after reset", mw_doe, 0);
      chk("R12 disabled after reset", write_enabled, 0);
      chk("R12 no requests", n_wr + n_er + n_eral + n_wral, 0);

      // R4 R5 reads, 16-bit and 8-bit, with wrap
      t_read(5, 2, 1'b1, 3);
      t_read(15, 2, 1'b1, 0);
      t_read(31, 2, 1'b0, 1);

      // R7 write while disabled
      org_wide = 1'b1;
      cs_on(); send(3'b101, 3); send(4'h3, AW); send(16'h1234, 16); cs_off();
      chk("R7 no write while disabled", n_wr, 0);
      cs_on();
      chk("R7 no status while disabled", mw_doe, 0);
      cs_off();

      // R2 enable
      cs_on(); send(3'b100, 3); send(4'b1100, AW); cs_off();
      chk("R2 R7 enable command", write_enabled, 1);

      // R8 write 16-bit
      cs_on(); send(3'b101, 3); send(4'h3, AW); send(16'hBEEF, 16);
      chk("R8 nothing before deselect", n_wr, 0);
      cs_off();
      chk("R8 write pulse", n_wr, 1);
      chk("R8 write address", int'(prog_addr), 3);
      chk("R8 write data", int'(prog_data), 16'hBEEF);
      cs_off();
      chk("R6 status hidden when deselected", mw_doe, 0);
      t_status();

      // R2 erase
      cs_on(); send(3'b111, 3); send(4'h9, AW); cs_off();
      chk("R2 erase pulse", n_er, 1);
      chk("R2 erase address", int'(prog_addr), 9);
      t_status();

      // R2 erase all
      cs_on(); send(3'b100, 3); send(4'b1011, AW); cs_off();
      chk("R2 erase-all pulse", n_eral, 1);
      t_status();

      // R3 write-all in 8-bit organization
      org_wide = 1'b0;
      cs_on(); send(3'b100, 3); send(5'b01101, AW + 1); send(8'h5C, 8); cs_off();
      chk("R3 write-all pulse", n_wral, 1);
      chk("R3 8-bit data", int'(prog_data), 16'h005C);
      t_status();
      chk("R3 no stray write", n_wr, 1);

      // R11 abort mid-data
      org_wide = 1'b1;
      cs_on(); send(3'b101, 3); send(4'h2, AW); send(3'b101, 3); cs_off();
      chk("R11 partial write dropped", n_wr, 1);
      cs_on();
      chk("R11 no status after abort", mw_doe, 0);
      cs_off();

      // R7 disable then erase is ignored
      cs_on(); send(3'b100, 3); send(4'b0010, AW); cs_off();
      chk("R7 disable command", write_enabled, 0);
      cs_on(); send(3'b111, 3); send(4'h1, AW); cs_off();
      chk("R7 erase ignored when disabled", n_er, 1);

      // R1 read still works after all of this, with leading zeros
      t_read(0, 1, 1'b1, 2);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule